// File: doc/BRIEF.md
# Sector-Granular Memory CRC Checker

This block computes a CRC-32 over a run of whole memory sectors and makes the result available to software. Software loads a sector-aligned start address into one register, then writes a sector count with a start request into a control register. When the request is accepted, a busy flag in the status register rises. The engine then reads the run one 32-bit word per cycle through a synchronous memory read port, folds each word into the CRC and, after the last word, drops busy and loads the checksum into a read-only result register.

Memory is split into a main region and an extension region. Each region is given as a base address and a sector count. A request is rejected if its start is not on a sector boundary, if its count is zero, or if the run does not lie entirely inside one region. A rejected request leaves busy low and sets a sticky error flag, which software clears by writing a one to it. All registers are 32-bit words on a simple register port with a combinational read.

Top module: `crc_sector_scan`

## Requirements
- R1: After reset, the address (0x84), control (0x88), result (0x8C) and status (0x0C) registers all read 0, and `mem_re` is low.
- R2: Register layout. 0x84 holds the start byte address. 0x88 holds the sector count in bits [15:0] and takes the start request in bit 16, which always reads back 0. 0x8C is read-only. In 0x0C, bit 0 is busy and bit 1 is error.
- R3: Busy reads 1 from the cycle after an accepted start until the run completes. It then reads 0.
- R4: During a run the engine reads every word of the run exactly once, one per cycle. Addresses increase by 4, starting at the start address. Read data is taken one cycle after `mem_re`. `mem_re` is never high while busy is 0.
- R5: The checksum is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. Each word is fed MSB first, with no reflection and no final XOR.
- R6: The result register changes only at the end of a run, and then it holds the checksum of that run. It stays stable while busy is 1.
- R7: A start address that is not a multiple of the sector size in bytes is rejected.
- R8: A start request with a sector count of 0 is rejected.
- R9: A run that crosses the main/extension boundary, or that extends outside both regions, is rejected.
- R10: A rejected request sets error (status bit 1), leaves busy at 0 and issues no memory read.
- R11: Error is sticky. It survives later successful runs and is cleared only by writing 1 to status bit 1.
- R12: While busy is 1, writes to the address and control registers are ignored, and a start request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address of the request |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_re` |

## Verification
The bench builds the block with 4-word (16-byte) sectors. The main region is 8 sectors at address 0x00, and the extension region is 4 sectors directly after it at 0x80. With these sizes, full-region runs, runs that end exactly at a region's last byte, boundary-crossing runs and runs past the extension's end all finish in a few dozen cycles. Having the two regions adjacent means a run can cross from one into the other with no gap between them, so the boundary rule is tested on its own rather than through an out-of-range address.

// File: rtl/crc_sector_scan.sv
module crc_sector_scan #(
  parameter int          ADDR_W       = 32,
  parameter int          SECTOR_WORDS = 256,
  parameter logic [31:0] MAIN_BASE    = 32'h0800_0000,
  parameter int          MAIN_SECTORS = 64,
  parameter logic [31:0] EXT_BASE     = 32'h0801_0000,
  parameter int          EXT_SECTORS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata
);
  localparam logic [31:0] POLY     = 32'h04C1_1DB7;
  localparam int          SEC_B    = SECTOR_WORDS * 4;
  localparam int          OFS_W    = $clog2(SEC_B);
  localparam int          LEFT_W   = 16 + $clog2(SECTOR_WORDS) + 1;
  localparam int          WIDE_W   = ADDR_W + 18;
  localparam logic [7:0]  OFS_STS  = 8'h0C;
  localparam logic [7:0]  OFS_ADR  = 8'h84;
  localparam logic [7:0]  OFS_CTL  = 8'h88;
  localparam logic [7:0]  OFS_RES  = 8'h8C;
  localparam logic [WIDE_W-1:0] MAIN_LO = WIDE_W'(MAIN_BASE);
  localparam logic [WIDE_W-1:0] MAIN_HI = WIDE_W'(MAIN_BASE) + WIDE_W'(MAIN_SECTORS) * WIDE_W'(SEC_B);
  localparam logic [WIDE_W-1:0] EXT_LO  = WIDE_W'(EXT_BASE);
  localparam logic [WIDE_W-1:0] EXT_HI  = WIDE_W'(EXT_BASE) + WIDE_W'(EXT_SECTORS) * WIDE_W'(SEC_B);

  logic [ADDR_W-1:0] start_q, ptr_q;
  logic [15:0]       count_q;
  logic [31:0]       crc_q, result_q;
  logic [LEFT_W-1:0] left_q;
  logic              busy_q, err_q, rd_vld_q;

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] d);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  wire wr      = reg_en && reg_we;
  wire wr_sts  = wr && reg_addr == OFS_STS;
  wire wr_adr  = wr && reg_addr == OFS_ADR && !busy_q;
  wire wr_ctl  = wr && reg_addr == OFS_CTL && !busy_q;
  wire go_req  = wr_ctl && reg_wdata[16];

  wire [15:0]       req_cnt  = reg_wdata[15:0];
  wire [WIDE_W-1:0] run_lo   = WIDE_W'(start_q);
  wire [WIDE_W-1:0] run_hi   = run_lo + WIDE_W'(req_cnt) * WIDE_W'(SEC_B);
  wire              aligned  = start_q[OFS_W-1:0] == '0;
  wire              in_main  = run_lo >= MAIN_LO && run_hi <= MAIN_HI;
  wire              in_ext   = run_lo >= EXT_LO  && run_hi <= EXT_HI;
  wire              req_ok   = aligned && req_cnt != 16'd0 && (in_main || in_ext);
  wire              finish   = busy_q && left_q == '0 && !rd_vld_q;

  assign mem_re   = busy_q && left_q != '0;
  assign mem_addr = ptr_q;

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_en && !reg_we) begin
      case (reg_addr)
        OFS_STS: reg_rdata = {30'd0, err_q, busy_q};
        OFS_ADR: reg_rdata = 32'(start_q);
        OFS_CTL: reg_rdata = {16'd0, count_q};
        OFS_RES: reg_rdata = result_q;
        default: reg_rdata = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      count_q  <= '0;
      result_q <= '0;
      crc_q    <= '1;
      ptr_q    <= '0;
      left_q   <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= mem_re;
      if (wr_adr) start_q <= reg_wdata[ADDR_W-1:0];
      if (wr_ctl) count_q <= req_cnt;
      if (wr_sts && reg_wdata[1]) err_q <= 1'b0;
      if (go_req) begin
        if (req_ok) begin
          busy_q <= 1'b1;
          ptr_q  <= start_q;
          left_q <= LEFT_W'(req_cnt) * LEFT_W'(SECTOR_WORDS);
          crc_q  <= '1;
        end else begin
          err_q  <= 1'b1;
        end
      end
      if (mem_re) begin
        ptr_q  <= ptr_q + ADDR_W'(4);
        left_q <= left_q - 1'b1;
      end
      if (rd_vld_q) crc_q <= crc_word(crc_q, mem_rdata);
      if (finish) begin
        busy_q   <= 1'b0;
        result_q <= crc_q;
      end
    end
  end

  // R4
  mem_re_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> busy_q);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) |-> mem_addr == $past(mem_addr) + ADDR_W'(4));

  // R7
  first_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> mem_re && mem_addr[OFS_W-1:0] == '0);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(result_q));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) && !$past(wr_sts && reg_wdata[1]) |-> err_q);

  // R12
  busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_q) |-> $stable(start_q) && $stable(count_q));

  // R10
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !busy_q && !mem_re);
endmodule

// File: tb/test_crc_sector_scan.sv
`timescale 1ns/1ps
module test_crc_sector_scan;
  localparam int SW = 4;
  localparam logic [31:0] MB = 32'h00, EB = 32'h80;
  localparam int MS = 8, ES = 4;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_en = 0, reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_re;
  logic [31:0] mem_addr, mem_rdata = 0;
  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] exp_addr = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  crc_sector_scan #(.ADDR_W(32), .SECTOR_WORDS(SW), .MAIN_BASE(MB), .MAIN_SECTORS(MS),
                    .EXT_BASE(EB), .EXT_SECTORS(ES)) i_crc_sector_scan (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata));

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A0F_C3A5 ^ {a[7:0], 24'h0};
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] s, input int words);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < words; w++) begin
      c = c ^ pattern(s + 32'(w * 4));
      for (int b = 0; b < 32; b++) c = c[31] ? ((c << 1) ^ POLY) : (c << 1);
    end
    return c;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_re) begin
      mem_rdata <= pattern(mem_addr);
      checks++;
      if (mem_addr !== exp_addr) begin
        fails++;
        $display("FAIL R4 read order: addr %h expected %h", mem_addr, exp_addr);
      end
      exp_addr <= exp_addr + 4;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rdreg(8'h0C, s);
      if (!s[0]) return;
    end
    fails++;
    $display("FAIL R3: busy never cleared");
  endtask

  typedef struct packed { logic [31:0] start; logic [15:0] cnt; logic bad; } vec_t;
  localparam vec_t VEC [10] = '{
    '{32'h00, 16'd1, 1'b0}, '{32'h10, 16'd3, 1'b0}, '{32'h00, 16'd8, 1'b0},
    '{32'h80, 16'd4, 1'b0}, '{32'h90, 16'd2, 1'b0}, '{32'h70, 16'd2, 1'b1},
    '{32'h14, 16'd1, 1'b1}, '{32'h20, 16'd0, 1'b1}, '{32'hB0, 16'd2, 1'b1},
    '{32'hC0, 16'd1, 1'b1}};

  initial begin
    logic [31:0] prev, st;
    #12 rst_n = 1;
    // R1 reset values
    rdreg(8'h84, rd); check("R1 addr", rd, 0);
    rdreg(8'h88, rd); check("R1 ctrl", rd, 0);
    rdreg(8'h8C, rd); check("R1 result", rd, 0);
    rdreg(8'h0C, rd); check("R1 status", rd, 0);
    check("R1 mem_re", {31'd0, mem_re}, 0);

    prev = 0;
    foreach (VEC[i]) begin
      wr(8'h84, VEC[i].start);
      exp_addr = VEC[i].start;
      wr(8'h88, {15'd0, 1'b1, VEC[i].cnt});
      rdreg(8'h0C, st);
      if (VEC[i].bad) begin
        // R7 R8 R9 R10: rejected, error set, busy low, result untouched
        check("R10 reject status", st, 32'h2);
        rdreg(8'h8C, rd); check("R9 result unchanged", rd, prev);
        wr(8'h0C, 32'h2);
        rdreg(8'h0C, rd); check("R11 w1c clears error", rd, 0);
      end else begin
        check("R3 busy after start", st, 32'h1);
        wait_idle();
        rdreg(8'h8C, rd);
        prev = ref_crc(VEC[i].start, VEC[i].cnt * SW);
        check("R5 crc", rd, prev);
        check("R4 word count", exp_addr, VEC[i].start + 32'(VEC[i].cnt) * SW * 4);
        rdreg(8'h88, rd); check("R2 ctrl readback, start reads 0", rd, {16'd0, VEC[i].cnt});
      end
    end

    // R12: writes during busy ignored
    wr(8'h84, 32'h40);
    exp_addr = 32'h40;
    wr(8'h88, 32'h1_0004);
    wr(8'h84, 32'h10);
    wr(8'h88, 32'h1_0001);
    rdreg(8'h84, rd); check("R12 addr held", rd, 32'h40);
    rdreg(8'h88, rd); check("R12 ctrl held", rd, 32'h4);
    // R6 result stable during run
    rdreg(8'h8C, rd); check("R6 result stable while busy", rd, prev);
    wait_idle();
    rdreg(8'h8C, rd); check("R12 result of first run", rd, ref_crc(32'h40, 16));
    rdreg(8'h0C, rd); check("R12 no error from ignored start", rd, 0);

    // R11 sticky across a good run
    wr(8'h84, 32'h04);
    wr(8'h88, 32'h1_0001);
    exp_addr = 32'h00;
    wr(8'h84, 32'h00);
    wr(8'h88, 32'h1_0001);
    wait_idle();
    rdreg(8'h0C, rd); check("R11 error survives run", rd, 32'h2);
    rdreg(8'h8C, rd); check("R5 crc one sector", rd, ref_crc(0, SW));
    wr(8'h0C, 32'h1);
    rdreg(8'h0C, rd); check("R11 writing bit0 keeps error", rd, 32'h2);
    wr(8'h0C, 32'h2);
    rdreg(8'h0C, rd); check("R11 cleared", rd, 0);
    rdreg(8'h10, rd); check("R2 unmapped reads 0", rd, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule